// File: doc/BRIEF.md
# Dual-Clock Serial Loader with Held Parallel Outputs

The block gathers a serial bit stream into a chain of shift stages and, on a separate command, copies the whole chain into a holding register that drives a parallel bus. Shifting and copying are started by two separate strobe levels, `shift_clk` and `store_clk`. Both are sampled by the chip clock `clk`, and the block acts on their rising edges. Because the two strobes are independent, a new word can be shifted in while the parallel bus still shows the previous word. The copy then happens in one step.

An active-low clear empties the shift stages without touching the holding register. An active-low output enable switches the parallel bus between showing the held word and being released. The bus is modelled as data plus a drive flag, and the data reads as zero when released. The last shift stage is brought out on `ser_out` regardless of the enable, so several instances can be chained by feeding each `ser_out` to the next `ser_in`.

Top module: `sr_latched_shifter`

## Requirements
- R1: On a `clk` edge where `shift_clk` is high and was low at the previous edge, with `clear_n` high, stage A (`par` bit 0) takes `ser_in` and every stage k moves to stage k+1. Stage H is bit WIDTH-1.
- R2: A `shift_clk` level held high for several cycles gives exactly one shift. Without a rising shift strobe the stages keep their contents.
- R3: While `clear_n` is low, the shift contents read as zero at once (on `ser_out` and towards the holding register), the stages are zeroed at the next `clk` edge, and rising shift strobes are ignored.
- R4: After `clear_n` returns high, the first rising shift strobe shifts into an all-zero chain.
- R5: On a rising `store_clk` the holding register copies the full shift contents. At all other times it keeps its value, including while shifting goes on.
- R6: `clear_n` never changes the holding register.
- R7: A rising `store_clk` while `clear_n` is low loads all zeros.
- R8: When both strobes rise at the same edge, the holding register gets the contents from before that shift.
- R9: With `out_en_n` low, `par_q` shows the holding register and `par_oe` is 1. With `out_en_n` high, `par_q` is 0 and `par_oe` is 0. The enable never alters either register.
- R10: `ser_out` always equals stage H, whatever `out_en_n` is, so chained instances form one longer shift register.
- R11: `rst` (synchronous, active high) zeroes the stages and the strobe history and leaves the holding register untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage A |
| shift_clk | input | 1 | Shift strobe; acts on its rising edge |
| store_clk | input | 1 | Copy strobe; acts on its rising edge |
| clear_n | input | 1 | Active-low clear of the shift stages |
| out_en_n | input | 1 | Active-low parallel bus enable |
| par_q | output | WIDTH | Parallel bus data, zero when released |
| par_oe | output | 1 | Parallel bus drive flag |
| ser_out | output | 1 | Stage H, for chaining |

## Verification
The hardest case to reach is a copy strobe that lands on the same edge as a shift strobe while a second instance is chained behind the first. That case must show the pre-shift word in both holding registers while both chains advance. The random stimulus issues simultaneous strobe pairs often and drives two chained instances. Copy strobes that land inside a clear window, and shift levels held high for several cycles, are also driven directly. Disabled-bus stretches with shifting and clearing are followed by re-enabling, to show that the held word survived.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int unsigned SR_DEF_WIDTH = 8;
    localparam int unsigned SR_STROBES   = 2;
    localparam int unsigned SR_IDX_SHIFT = 0;
    localparam int unsigned SR_IDX_STORE = 1;

    typedef struct packed {
        logic store_evt;
        logic shift_evt;
    } sr_evt_t;

    function automatic logic sr_rising(input logic cur, input logic last);
        return cur & ~last;
    endfunction
endpackage

// File: rtl/sr_edge_det.sv
module sr_edge_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= lvl;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_ch
            assign rise[i] = sr_pkg::sr_rising(lvl[i], last_q[i]);

            // R2
            rise_single_chk: assert property (@(posedge clk) disable iff (rst)
                rise[i] |=> !rise[i]);
        end
    endgenerate
endmodule

// File: rtl/sr_shift_chain.sv
module sr_shift_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_n,
    input  logic             shift_evt,
    input  logic             ser_in,
    output logic [WIDTH-1:0] view,
    output logic             ser_out
);
    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] stages_q;

    always_ff @(posedge clk) begin
        if (rst || !clear_n)
            stages_q <= '0;
        else if (shift_evt)
            stages_q <= {stages_q[TOP-1:0], ser_in};
    end

    assign view    = clear_n ? stages_q : '0;
    assign ser_out = view[TOP];

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_evt && clear_n) |=> stages_q == {$past(stages_q[TOP-1:0]), $past(ser_in)});

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_evt && clear_n) |=> $stable(stages_q));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> stages_q == '0);
endmodule

// File: rtl/sr_hold_stage.sv
module sr_hold_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store_evt,
    input  logic [WIDTH-1:0] word_in,
    input  logic             out_en_n,
    output logic [WIDTH-1:0] par_q,
    output logic             par_oe
);
    logic [WIDTH-1:0] held_q;

    always_ff @(posedge clk) begin
        if (store_evt) held_q <= word_in;
    end

    assign par_oe = ~out_en_n;
    assign par_q  = par_oe ? held_q : '0;

    // R5
    store_copy_chk: assert property (@(posedge clk) disable iff (rst)
        store_evt |=> held_q == $past(word_in));

    // R5
    store_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !store_evt |=> $stable(held_q));

    // R9
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (par_q == '0 && !par_oe));
endmodule

// File: rtl/sr_latched_shifter.sv
module sr_latched_shifter #(
    parameter int unsigned WIDTH = sr_pkg::SR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clear_n,
    input  logic             out_en_n,
    output logic [WIDTH-1:0] par_q,
    output logic             par_oe,
    output logic             ser_out
);
    import sr_pkg::*;

    logic [SR_STROBES-1:0] lvl;
    logic [SR_STROBES-1:0] rise;
    sr_evt_t               evt;
    logic [WIDTH-1:0]      chain_view;

    assign lvl[SR_IDX_SHIFT] = shift_clk;
    assign lvl[SR_IDX_STORE] = store_clk;

    sr_edge_det #(.N(SR_STROBES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .rise (rise)
    );

    assign evt.shift_evt = rise[SR_IDX_SHIFT];
    assign evt.store_evt = rise[SR_IDX_STORE];

    sr_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .clear_n   (clear_n),
        .shift_evt (evt.shift_evt),
        .ser_in    (ser_in),
        .view      (chain_view),
        .ser_out   (ser_out)
    );

    sr_hold_stage #(.WIDTH(WIDTH)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .store_evt (evt.store_evt),
        .word_in   (chain_view),
        .out_en_n  (out_en_n),
        .par_q     (par_q),
        .par_oe    (par_oe)
    );

    // R7
    clear_store_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.store_evt && !clear_n && !out_en_n) |=> (out_en_n || par_q == '0));

    // R3
    clear_serial_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> !ser_out);
endmodule

// File: tb/sr_latched_shifter_tb.sv
module sr_latched_shifter_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sin = 1'b0, sck = 1'b0, rck = 1'b0, clr_n = 1'b1, oe_n = 1'b1;
    logic [W-1:0] pq_a, pq_b;
    logic oe_a, oe_b, so_a, so_b;

    logic [W-1:0] ma = '0, mb = '0, sa = '0, sb = '0;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sr_latched_shifter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .ser_in(sin), .shift_clk(sck), .store_clk(rck),
        .clear_n(clr_n), .out_en_n(oe_n), .par_q(pq_a), .par_oe(oe_a), .ser_out(so_a));

    sr_latched_shifter #(.WIDTH(W)) u_dut_b (
        .clk(clk), .rst(rst), .ser_in(so_a), .shift_clk(sck), .store_clk(rck),
        .clear_n(clr_n), .out_en_n(oe_n), .par_q(pq_b), .par_oe(oe_b), .ser_out(so_b));

    function automatic logic [W-1:0] exp_bus(input logic [W-1:0] held, input logic en_n);
        return en_n ? '0 : held;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "par_q_a", pq_a, exp_bus(sa, oe_n));
        cmp(tag, "par_q_b", pq_b, exp_bus(sb, oe_n));
        cmp(tag, "par_oe_a", {7'd0, oe_a}, {7'd0, ~oe_n});
        cmp(tag, "ser_out_a", {7'd0, so_a}, {7'd0, ma[W-1]});
        cmp(tag, "ser_out_b", {7'd0, so_b}, {7'd0, mb[W-1]});
    endtask

    task automatic model_edge(input logic s, input logic r, input logic d);
        logic [W-1:0] na, nb;
        if (r) begin
            sa = clr_n ? ma : '0;
            sb = clr_n ? mb : '0;
        end
        if (s && clr_n) begin
            na = {ma[W-2:0], d};
            nb = {mb[W-2:0], ma[W-1]};
            ma = na;
            mb = nb;
        end
    endtask

    task automatic pulse(input logic s, input logic r, input logic d, input string tag);
        @(negedge clk);
        sin = d; sck = s; rck = r;
        @(negedge clk);
        model_edge(s, r, d);
        sck = 1'b0; rck = 1'b0;
        check_all(tag);
    endtask

    task automatic clear_pulse(input string tag);
        @(negedge clk);
        clr_n = 1'b0; ma = '0; mb = '0;
        #1 check_all(tag);
        @(negedge clk);
        clr_n = 1'b1;
        check_all(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0595));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state: stages zero, bus released
        @(negedge clk);
        check_all("R11");
        // initialise holding registers: clear then copy (R7)
        @(negedge clk); clr_n = 1'b0;
        pulse(1'b0, 1'b1, 1'b0, "R7");
        @(negedge clk); clr_n = 1'b1;
        oe_n = 1'b0;
        @(negedge clk); check_all("R7");

        // R1 directed: load 1011_0010 MSB first into A
        for (int i = W - 1; i >= 0; i--) pulse(1'b1, 1'b0, logic'(8'hB2 >> i), "R1");
        cmp("R1", "stage H bit", {7'd0, so_a}, 8'd1);
        // R5: bus still holds zeros while shifting, then copy
        cmp("R5", "bus held during shift", pq_a, 8'h00);
        pulse(1'b0, 1'b1, 1'b0, "R5");
        cmp("R5", "copied word", pq_a, 8'hB2);

        // R2: shift level held high several cycles gives one shift
        @(negedge clk); sin = 1'b1; sck = 1'b1;
        repeat (4) @(negedge clk);
        model_edge(1'b1, 1'b0, 1'b1);
        sck = 1'b0;
        @(negedge clk);
        check_all("R2");
        pulse(1'b0, 1'b1, 1'b0, "R2");
        cmp("R2", "single shift word", pq_a, 8'h65);

        // R8: simultaneous strobes copy the pre-shift word
        pulse(1'b1, 1'b1, 1'b0, "R8");
        cmp("R8", "pre-shift copy", pq_a, 8'h65);

        // R3/R6/R7: clear held low, shift ignored, holding untouched, copy loads zero
        @(negedge clk); clr_n = 1'b0; ma = '0; mb = '0;
        #1 check_all("R3");
        cmp("R6", "holding kept on clear", pq_a, sa);
        pulse(1'b1, 1'b0, 1'b1, "R3");
        cmp("R6", "holding kept after clear edge", pq_a, 8'h65);
        pulse(1'b0, 1'b1, 1'b0, "R7");
        cmp("R7", "zero copy under clear", pq_a, 8'h00);
        @(negedge clk); clr_n = 1'b1;
        // R4: first shift after release starts from zero
        pulse(1'b1, 1'b0, 1'b1, "R4");
        pulse(1'b0, 1'b1, 1'b0, "R4");
        cmp("R4", "clean first shift", pq_a, 8'h01);

        // R9/R10: bus released, serial path unaffected, registers kept
        @(negedge clk); oe_n = 1'b1;
        for (int i = 0; i < W; i++) pulse(1'b1, 1'b0, 1'b1, "R10");
        cmp("R10", "ser_out while released", {7'd0, so_a}, 8'd1);
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk); check_all("R9");
        cmp("R9", "held word survives release", pq_a, 8'h01);

        // random mix on the chained pair
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom % 8;
            case (op)
                0, 1, 2: pulse(1'b1, 1'b0, logic'($urandom % 2), "R1/R10");
                3:       pulse(1'b0, 1'b1, 1'b0, "R5");
                4:       pulse(1'b1, 1'b1, logic'($urandom % 2), "R8");
                5: begin
                    @(negedge clk); oe_n = ~oe_n;
                    @(negedge clk); check_all("R9");
                end
                6:       clear_pulse("R3/R6");
                default: pulse(1'b0, 1'b0, logic'($urandom % 2), "R2");
            endcase
        end

        // R11: reset zeroes the stages, holding register kept
        @(negedge clk); oe_n = 1'b0;
        for (int i = 0; i < W; i++) pulse(1'b1, 1'b0, 1'b1, "R11");
        pulse(1'b0, 1'b1, 1'b0, "R11");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        ma = '0; mb = '0;
        @(negedge clk);
        check_all("R11");
        cmp("R11", "holding after reset", pq_a, 8'hFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule